// File: doc/BRIEF.md
# Three-Multiplier Fast Integer Multiplier

This block multiplies two 32-bit integer operands for the four multiply operations of a 32-bit integer instruction set: the low product word, and the high product word with both operands signed, the first signed and the second unsigned, or both unsigned. The multiply is spread over exactly three 17-bit by 17-bit signed multipliers. Each 16-bit half of an operand is widened to 17 bits. A lower half always gets a zero top bit. An upper half gets its sign bit when that operand is treated as signed, and a zero otherwise. One signed multiplier therefore serves all four operations.

The caller raises `start_i` for one cycle with the operator code and both operands. The first cycle forms the low-by-low product and the two cross products. Their sum gives the low word at once. For a high-word operation, the upper part of that sum is held in a small register. In the second cycle the first multiplier is reused for the high-by-high product, which is added to the held part. `valid_o` rises for one cycle with the result, and `result_o` keeps its value until the next result. A start that arrives while a high-word operation is in its second cycle is dropped.

Top module: `mul3_fast`

## Requirements
- R1: After reset `valid_o` is 0 and `result_o` is 0.
- R2: A start with `op_i` = 2'b00 gives the low 32 bits of the product in the following cycle, with `valid_o` high in that cycle.
- R3: A start with `op_i` = 2'b01 gives bits 63:32 of the product of both operands taken as signed. `valid_o` is low in the following cycle and high in the cycle after it.
- R4: A start with `op_i` = 2'b10 gives bits 63:32 of the product of signed `a_i` and unsigned `b_i`, with the same two-cycle timing as R3.
- R5: A start with `op_i` = 2'b11 gives bits 63:32 of the unsigned product, with the same two-cycle timing as R3.
- R6: `valid_o` is high for exactly one cycle per accepted operation. While no operation completes, `valid_o` is low and `result_o` holds its last value.
- R7: A start raised in the second cycle of a high-word operation is ignored. It produces no result and does not disturb the result in progress.
- R8: Low-word starts may be issued in consecutive cycles, and each one produces its own result one cycle later.
- R9: Operand corners give exact results for every operator: most negative value times minus one, zero operands, all ones, and values at the 16-bit half boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, one cycle per operation |
| op_i | input | 2 | 00 low word, 01 high signed, 10 high signed-unsigned, 11 high unsigned |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Product word |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The block keeps only a phase flag, the upper high operand halves and a carried partial sum. A wrong phase shows up at the ports within one cycle: either a misplaced or missing `valid_o` pulse, or a start that is swallowed or accepted when it should not be. A corrupted carried sum or stale operand halves appear only in the high word, exactly two cycles after the start. That is why every high-word operator is compared against a 64-bit reference product, with sign-sensitive corners, in the cycle its strobe is due.

// File: rtl/mul3_pkg.sv
package mul3_pkg;

    typedef enum logic [1:0] {
        OP_LOW    = 2'b00,
        OP_HI_SS  = 2'b01,
        OP_HI_SU  = 2'b10,
        OP_HI_UU  = 2'b11
    } mul_op_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } mul_phase_e;

endpackage

// File: rtl/mul3_split.sv
module mul3_split
    import mul3_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned HALF_W = DATA_W / 2,
    localparam int unsigned EXT_W  = HALF_W + 1
) (
    input  mul_op_e                  op_i,
    input  logic [DATA_W-1:0]        a_i,
    input  logic [DATA_W-1:0]        b_i,
    output logic signed [EXT_W-1:0]  a_lo_o,
    output logic signed [EXT_W-1:0]  a_hi_o,
    output logic signed [EXT_W-1:0]  b_lo_o,
    output logic signed [EXT_W-1:0]  b_hi_o
);
    logic a_sgn;
    logic b_sgn;

    always_comb begin
        a_sgn  = (op_i == OP_HI_SS) || (op_i == OP_HI_SU);
        b_sgn  = (op_i == OP_HI_SS);
        a_lo_o = {1'b0, a_i[HALF_W-1:0]};
        b_lo_o = {1'b0, b_i[HALF_W-1:0]};
        a_hi_o = {a_sgn & a_i[DATA_W-1], a_i[DATA_W-1:HALF_W]};
        b_hi_o = {b_sgn & b_i[DATA_W-1], b_i[DATA_W-1:HALF_W]};
    end

endmodule

// File: rtl/mul3_smul.sv
module mul3_smul #(
    parameter int unsigned EXT_W = 17,
    localparam int unsigned PROD_W = 2 * EXT_W
) (
    input  logic signed [EXT_W-1:0]  x_i,
    input  logic signed [EXT_W-1:0]  y_i,
    output logic signed [PROD_W-1:0] p_o
);
    always_comb begin
        p_o = x_i * y_i;
    end
endmodule

// File: rtl/mul3_fast.sv
module mul3_fast
    import mul3_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned EXT_W  = HALF_W + 1;
    localparam int unsigned PROD_W = 2 * EXT_W;
    localparam int unsigned SUM_W  = PROD_W + HALF_W + 2;
    localparam int unsigned ACC_W  = SUM_W - DATA_W;
    localparam int unsigned N_MUL  = 3;

    typedef struct packed {
        mul_phase_e               phase;
        logic signed [ACC_W-1:0]  acc;
        logic signed [EXT_W-1:0]  a_hi;
        logic signed [EXT_W-1:0]  b_hi;
        logic [DATA_W-1:0]        result;
        logic                     valid;
    } mul_state_t;

    mul_state_t st_d;
    mul_state_t st_q;
    logic       busy;

    mul_op_e op;
    logic signed [EXT_W-1:0]  a_lo, a_hi, b_lo, b_hi;
    logic signed [EXT_W-1:0]  mx [N_MUL];
    logic signed [EXT_W-1:0]  my [N_MUL];
    logic signed [PROD_W-1:0] mp [N_MUL];

    logic signed [SUM_W-1:0]  t_ll, t_lh, t_hl, sum1;
    logic signed [PROD_W-1:0] acc_ext;
    logic [DATA_W-1:0]        hi_word;

    assign op   = mul_op_e'(op_i);
    assign busy = (st_q.phase == PH_SECOND);

    mul3_split #(.DATA_W(DATA_W)) u_split (
        .op_i   (op),
        .a_i    (a_i),
        .b_i    (b_i),
        .a_lo_o (a_lo),
        .a_hi_o (a_hi),
        .b_lo_o (b_lo),
        .b_hi_o (b_hi)
    );

    // Multiplier 0 is shared: low-by-low in the first phase, high-by-high in the second.
    always_comb begin
        mx[0] = busy ? st_q.a_hi : a_lo;
        my[0] = busy ? st_q.b_hi : b_lo;
        mx[1] = a_lo;
        my[1] = b_hi;
        mx[2] = a_hi;
        my[2] = b_lo;
    end

    for (genvar g = 0; g < N_MUL; g++) begin : g_mul
        mul3_smul #(.EXT_W(EXT_W)) u_mul (
            .x_i (mx[g]),
            .y_i (my[g]),
            .p_o (mp[g])
        );
    end

    always_comb begin
        t_ll    = mp[0];
        t_lh    = mp[1];
        t_hl    = mp[2];
        sum1    = t_ll + (t_lh <<< HALF_W) + (t_hl <<< HALF_W);
        acc_ext = st_q.acc;
        hi_word = DATA_W'(mp[0] + acc_ext);

        st_d       = st_q;
        st_d.valid = 1'b0;
        unique case (st_q.phase)
            PH_FIRST: begin
                if (start_i) begin
                    if (op == OP_LOW) begin
                        st_d.result = sum1[DATA_W-1:0];
                        st_d.valid  = 1'b1;
                    end else begin
                        st_d.acc   = sum1[SUM_W-1:DATA_W];
                        st_d.a_hi  = a_hi;
                        st_d.b_hi  = b_hi;
                        st_d.phase = PH_SECOND;
                    end
                end
            end
            PH_SECOND: begin
                st_d.result = hi_word;
                st_d.valid  = 1'b1;
                st_d.phase  = PH_FIRST;
            end
            default: st_d.phase = PH_FIRST;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign valid_o  = st_q.valid;

endmodule

// File: rtl/mul3_fast_chk.sv
module mul3_fast_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [1:0]        op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [DATA_W-1:0] result_o,
    input logic              valid_o,
    input logic              busy_i
);
    // R2: low word one cycle after an accepted low-word start
    a_r2_low_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_i && op_i == 2'b00) |=>
            (valid_o && result_o == DATA_W'($past(a_i) * $past(b_i))));

    // R3, R4, R5: high-word start gives no strobe in the next cycle
    a_r3_high_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_i && op_i != 2'b00) |=> (busy_i && !valid_o));

    // R7: second phase lasts one cycle and ends with the strobe, whatever start does
    a_r7_second_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> (valid_o && !busy_i));

    // R6: idle cycle produces no strobe and keeps the result
    a_r6_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && !busy_i) |=> (!valid_o && $stable(result_o)));

endmodule

bind mul3_fast mul3_fast_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .valid_o  (valid_o),
    .busy_i   (busy)
);

// File: tb/tb_mul3_fast.sv
module tb_mul3_fast;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] result;
    logic        valid;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mul3_fast dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .result_o (result),
        .valid_o  (valid)
    );

    function automatic logic [31:0] ref_res(input logic [1:0] o, input logic [31:0] x,
                                            input logic [31:0] y);
        logic [63:0] ex, ey, p;
        ex = (o == 2'b01 || o == 2'b10) ? {{32{x[31]}}, x} : {32'h0, x};
        ey = (o == 2'b01) ? {{32{y[31]}}, y} : {32'h0, y};
        p  = ex * ey;
        return (o == 2'b00) ? p[31:0] : p[63:32];
    endfunction

    function automatic string op_tag(input logic [1:0] o);
        case (o)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // one operation with idle afterwards; checks strobe timing and value
    task automatic run_op(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                          input string extra);
        string tag;
        tag = {op_tag(o), extra};
        @(negedge clk);
        start = 1'b1; op = o; a = x; b = y;
        @(negedge clk);
        start = 1'b0;
        if (o == 2'b00) begin
            check({tag, " valid"}, 32'(valid), 32'd1);
            check({tag, " value"}, result, ref_res(o, x, y));
        end else begin
            check({tag, " early valid"}, 32'(valid), 32'd0);
            @(negedge clk);
            check({tag, " valid"}, 32'(valid), 32'd1);
            check({tag, " value"}, result, ref_res(o, x, y));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(valid), 32'd0);
        check("R1 result", result, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_corners();
        logic [31:0] va [8] = '{32'h8000_0000, 32'h0, 32'h1234_5678, 32'hFFFF_FFFF,
                               32'h7FFF_FFFF, 32'h0000_FFFF, 32'h0000_8000, 32'h0001_0000};
        logic [31:0] vb [8] = '{32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0, 32'hFFFF_FFFF,
                               32'h8000_0000, 32'h0000_FFFF, 32'h0000_8000, 32'hFFFF_0000};
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 4; k++) begin
                run_op(2'(k), va[i], vb[i], " R9 corner");
            end
        end
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            run_op(2'($urandom_range(0, 3)), $urandom, $urandom, " random");
        end
    endtask

    task automatic t_quiet();
        logic [31:0] held;
        @(negedge clk);
        held = result;
        repeat (3) begin
            @(negedge clk);
            check("R6 idle valid", 32'(valid), 32'd0);
            check("R6 result held", result, held);
        end
    endtask

    task automatic t_ignore();
        @(negedge clk);
        start = 1'b1; op = 2'b01; a = 32'hF000_0001; b = 32'h0000_0003;
        @(negedge clk);
        check("R7 no early valid", 32'(valid), 32'd0);
        op = 2'b00; a = 32'h0000_0005; b = 32'h0000_0007;
        @(negedge clk);
        start = 1'b0;
        check("R7 valid", 32'(valid), 32'd1);
        check("R7 result kept", result, ref_res(2'b01, 32'hF000_0001, 32'h0000_0003));
        @(negedge clk);
        check("R7 dropped start no valid", 32'(valid), 32'd0);
        check("R7 dropped start no result", result,
              ref_res(2'b01, 32'hF000_0001, 32'h0000_0003));
    endtask

    task automatic t_back2back();
        @(negedge clk);
        start = 1'b1; op = 2'b00; a = 32'h0001_2345; b = 32'h0006_789A;
        @(negedge clk);
        check("R8 first valid", 32'(valid), 32'd1);
        check("R8 first value", result, ref_res(2'b00, 32'h0001_2345, 32'h0006_789A));
        a = 32'hFFFF_FFFE; b = 32'h8000_0003;
        @(negedge clk);
        start = 1'b0;
        check("R8 second valid", 32'(valid), 32'd1);
        check("R8 second value", result, ref_res(2'b00, 32'hFFFF_FFFE, 32'h8000_0003));
        @(negedge clk);
        check("R6 single pulse", 32'(valid), 32'd0);
        check("R6 hold after burst", result, ref_res(2'b00, 32'hFFFF_FFFE, 32'h8000_0003));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_quiet();
        t_corners();
        t_ignore();
        t_back2back();
        t_random();
        t_quiet();
        finish_run();
    end

endmodule